// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer execution stage for the register-to-register operations of a 32-bit load/store processor. Each cycle it receives a 4-bit operation code, a first operand A and a second operand M. M arrives already shifted or rotated by earlier logic. The block also receives a set-flags request, an indication that the destination is the program counter, and the carry value used by the carry-consuming operations. From these it computes a 32-bit result and a write-enable for the result combinationally.

It also keeps a four-bit condition register holding negative, zero, carry and overflow. This register updates on the clock edge after a strobed operation that asks for a flag update. Subtraction reports carry as "no borrow". The subtract-with-carry forms consume the incoming carry as `carry - 1`. The four comparison and test codes affect only the flags.

Top module: `dp_alu_core`

## Requirements
- R1: Logical codes give: 0000 A&M, 0001 A^M, 1100 A|M, 1101 M, 1110 A&~M, 1111 ~M.
- R2: Addition codes give: 0100 A+M and 0101 A+M+carry_i.
- R3: Subtraction codes give: 0010 A-M, 0011 M-A, 0110 A-M+carry_i-1 and 0111 M-A+carry_i-1.
- R4: Codes 1000 (A&M), 1001 (A^M), 1010 (A-M) and 1011 (A+M) never assert result_we_o. All other codes assert it whenever valid_i is high.
- R5: result_we_o stays low while valid_i is low.
- R6: The flag register loads only on a clock edge where valid_i=1, set_flags_i=1 and dest_pc_i=0. On every other edge it holds its value.
- R7: After an addition-class update (0100, 0101, 1011), C is the carry out of bit 31 and V is the signed overflow of the addition.
- R8: After a subtraction-class update (0010, 0011, 0110, 0111, 1010), C is 1 exactly when no borrow occurs. C and V are evaluated with the operands swapped for the reverse codes 0011 and 0111.
- R9: After a logical-class update (0000, 0001, 1000, 1001, 1100 to 1111), C is cleared and V keeps its old value.
- R10: Reset (rst_n low) clears all four flags. nzcv_o holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R11: Arithmetic wraps modulo 2^32 without any other effect. For example, 0xFFFFFFFF+1 gives 0.
- R12: On every update, N takes result bit 31 and Z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An operation is presented this cycle |
| opcode_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand A |
| opm_i | input | 32 | Pre-shifted second operand M |
| set_flags_i | input | 1 | Request a flag update |
| dest_pc_i | input | 1 | Destination is the program counter (blocks flag update) |
| carry_i | input | 1 | Carry value used by codes 0101, 0110, 0111 |
| result_o | output | 32 | Combinational result |
| result_we_o | output | 1 | Result write-enable |
| nzcv_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench targets several corner cases and the failure each one would reveal:

- **Carry-in on the subtract-with-carry codes, both polarities.** A design that treats carry as a borrow gives a result off by one.
- **Equal operands and a zero minuend.** These show whether subtraction carry is "no borrow": a design that reports borrow instead sets C backwards.
- **Reverse codes with asymmetric operands.** Without the operand swap, the reverse codes get wrong C and V.
- **0x7FFFFFFF and 0x80000000 operands.** These probe signed overflow. A sign-check mistake shows up as a V flip.
- **Held flag state.** The bench follows logical updates, cleared set-flags requests, program-counter destinations and idle cycles. A flag register that loads too eagerly, or that clears V on logical operations, diverges from the reference model.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  parameter int DATA_W = 32;
  localparam int MSB = DATA_W - 1;

  typedef enum logic [3:0] {
    ALU_AND    = 4'b0000,
    ALU_XOR    = 4'b0001,
    ALU_SUBF   = 4'b0010,
    ALU_SUBR   = 4'b0011,
    ALU_ADD    = 4'b0100,
    ALU_ADDC   = 4'b0101,
    ALU_SUBFC  = 4'b0110,
    ALU_SUBRC  = 4'b0111,
    ALU_TSTAND = 4'b1000,
    ALU_TSTXOR = 4'b1001,
    ALU_CMPSUB = 4'b1010,
    ALU_CMPADD = 4'b1011,
    ALU_OR     = 4'b1100,
    ALU_PASS   = 4'b1101,
    ALU_CLR    = 4'b1110,
    ALU_INV    = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Operation class decoders
  function automatic logic is_sub_op(input logic [3:0] op);
    return (op == ALU_SUBF) || (op == ALU_SUBR) || (op == ALU_SUBFC) ||
           (op == ALU_SUBRC) || (op == ALU_CMPSUB);
  endfunction

  function automatic logic is_add_op(input logic [3:0] op);
    return (op == ALU_ADD) || (op == ALU_ADDC) || (op == ALU_CMPADD);
  endfunction

  function automatic logic is_test_op(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic uses_carry(input logic [3:0] op);
    return (op == ALU_ADDC) || (op == ALU_SUBFC) || (op == ALU_SUBRC);
  endfunction

  function automatic logic is_reverse(input logic [3:0] op);
    return (op == ALU_SUBR) || (op == ALU_SUBRC);
  endfunction

  // Flag equations in bitwise form on the top bit of each term
  function automatic logic add_carry(input logic [MSB:0] a, m, r);
    logic [MSB:0] t;
    t = (a & m) | (m & ~r) | (a & ~r);
    return t[MSB];
  endfunction

  function automatic logic add_ovf(input logic [MSB:0] a, m, r);
    logic [MSB:0] t;
    t = (a & m & ~r) | (~a & ~m & r);
    return t[MSB];
  endfunction

  function automatic logic sub_carry(input logic [MSB:0] a, m, r);
    logic [MSB:0] t;
    t = (~a & m) | (m & r) | (r & ~a);
    return ~t[MSB];
  endfunction

  function automatic logic sub_ovf(input logic [MSB:0] a, m, r);
    logic [MSB:0] t;
    t = (a & ~m & ~r) | (~a & m & r);
    return t[MSB];
  endfunction
endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND, ALU_TSTAND: res_o = a_i & m_i;
      ALU_XOR, ALU_TSTXOR: res_o = a_i ^ m_i;
      ALU_OR:              res_o = a_i | m_i;
      ALU_PASS:            res_o = m_i;
      ALU_CLR:             res_o = a_i & ~m_i;
      ALU_INV:             res_o = ~m_i;
      default:             res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
  import dp_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  logic         sub_sel;
  logic         rev_sel;
  logic         cy_sel;
  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic [W-1:0] y_eff;
  logic [W-1:0] inc;

  assign sub_sel = is_sub_op(op_i);
  assign rev_sel = is_reverse(op_i);
  assign cy_sel  = uses_carry(op_i);

  // Reverse forms exchange operands before both the sum and the flags
  assign x_op  = rev_sel ? m_i : a_i;
  assign y_op  = rev_sel ? a_i : m_i;
  assign y_eff = sub_sel ? ~y_op : y_op;

  // Subtraction: x + ~y + 1, or x + ~y + C for the carry forms (C-1 borrow)
  always_comb begin
    if (sub_sel) inc = cy_sel ? W'(cin_i) : W'(1);
    else         inc = cy_sel ? W'(cin_i) : W'(0);
  end

  assign res_o = x_op + y_eff + inc;

  always_comb begin
    if (sub_sel) begin
      c_o = sub_carry(x_op, y_op, res_o);
      v_o = sub_ovf(x_op, y_op, res_o);
    end else begin
      c_o = add_carry(x_op, y_op, res_o);
      v_o = add_ovf(x_op, y_op, res_o);
    end
  end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
  import dp_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_i,
  input  logic  logic_i,
  input  logic  zero_i,
  input  nzcv_t next_i,
  output nzcv_t flags_o
);
  nzcv_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (upd_i) flags_q <= next_i;
  end

  assign flags_o = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_q)); // R6
  AST_LOGIC_C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && logic_i) |=> !flags_q.c); // R9
  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && logic_i) |=> (flags_q.v == $past(flags_q.v))); // R9
  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (flags_q.z == $past(zero_i))); // R12
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   opcode_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opm_i,
  input  logic         set_flags_i,
  input  logic         dest_pc_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic [3:0]   nzcv_o
);
  logic [W-1:0] logic_res;
  logic [W-1:0] arith_res;
  logic         arith_c;
  logic         arith_v;
  logic         arith_sel;
  logic         test_sel;
  logic         flag_upd;
  logic         res_zero;
  nzcv_t        flags_cur;
  nzcv_t        flags_nxt;

  dp_logic_unit #(.W(W)) u_logic (
    .op_i (opcode_i),
    .a_i  (opa_i),
    .m_i  (opm_i),
    .res_o(logic_res)
  );

  dp_arith_unit #(.W(W)) u_arith (
    .op_i (opcode_i),
    .a_i  (opa_i),
    .m_i  (opm_i),
    .cin_i(carry_i),
    .res_o(arith_res),
    .c_o  (arith_c),
    .v_o  (arith_v)
  );

  assign arith_sel   = is_sub_op(opcode_i) || is_add_op(opcode_i);
  assign test_sel    = is_test_op(opcode_i);
  assign result_o    = arith_sel ? arith_res : logic_res;
  assign result_we_o = valid_i && !test_sel;
  assign flag_upd    = valid_i && set_flags_i && !dest_pc_i;
  assign res_zero    = (result_o == '0);

  always_comb begin
    flags_nxt.n = result_o[W-1];
    flags_nxt.z = res_zero;
    flags_nxt.c = arith_sel ? arith_c : 1'b0;
    flags_nxt.v = arith_sel ? arith_v : flags_cur.v;
  end

  dp_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (flag_upd),
    .logic_i(!arith_sel),
    .zero_i (res_zero),
    .next_i (flags_nxt),
    .flags_o(flags_cur)
  );

  assign nzcv_o = flags_cur;

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_i[3:2] == 2'b10) |-> !result_we_o); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !result_we_o); // R5
  AST_PC_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dest_pc_i) |=> $stable(nzcv_o)); // R6
  AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (nzcv_o[3] == $past(result_o[W-1]))); // R12
endmodule

// File: tb/sim_dp_alu_core.sv
module sim_dp_alu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opm_i = '0;
  logic        set_flags_i = 1'b0;
  logic        dest_pc_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        result_we_o;
  logic [3:0]  nzcv_o;

  int total = 0;
  int bad = 0;
  logic [3:0] mdl = 4'b0000;
  logic [3:0] q_exp[$];
  string      q_tag[$];
  logic       done = 1'b0;

  always #4 clk = ~clk;

  dp_alu_core u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation, checks combinational outputs,
  // queues the flag value expected after the next edge.
  task automatic drive(input logic [3:0] op, input logic [31:0] a, m,
                       input logic s, pc, cin, vld, input string tag);
    logic [32:0] wide;
    logic [31:0] x, y, r;
    logic        cf, vf, arith, subf;
    string       rt, ft;
    @(negedge clk);
    valid_i = vld; opcode_i = op; opa_i = a; opm_i = m;
    set_flags_i = s; dest_pc_i = pc; carry_i = cin;
    arith = 1'b0; subf = 1'b0; cf = 1'b0; vf = mdl[0]; r = '0; rt = "R1";
    case (op)
      4'b0000, 4'b1000: r = a & m;
      4'b0001, 4'b1001: r = a ^ m;
      4'b1100: r = a | m;
      4'b1101: r = m;
      4'b1110: r = a & ~m;
      4'b1111: r = ~m;
      default: begin
        arith = 1'b1;
        subf = !(op == 4'b0100 || op == 4'b0101 || op == 4'b1011);
        x = (op == 4'b0011 || op == 4'b0111) ? m : a;
        y = (op == 4'b0011 || op == 4'b0111) ? a : m;
        if (subf) begin
          y = ~y;
          wide = {1'b0, x} + {1'b0, y} +
                 ((op == 4'b0110 || op == 4'b0111) ? 33'(cin) : 33'd1);
          rt = "R3";
        end else begin
          wide = {1'b0, x} + {1'b0, y} + ((op == 4'b0101) ? 33'(cin) : 33'd0);
          rt = "R2";
        end
        r  = wide[31:0];
        cf = wide[32];
        vf = (x[31] == y[31]) && (r[31] != x[31]);
      end
    endcase
    if (tag != "") rt = tag;
    #1;
    if (vld) check(rt, result_o, r);
    check((op[3:2] == 2'b10 || vld) ? "R4" : "R5", {31'd0, result_we_o},
          {31'd0, vld && op[3:2] != 2'b10});
    if (vld && s && !pc) begin
      mdl = {r[31], r == 32'd0, cf, vf};
      ft = !arith ? "R9" : (subf ? "R8" : "R7");
    end else ft = "R6";
    q_exp.push_back(mdl);
    q_tag.push_back(ft);
  endtask

  // Monitor: compares registered flags one edge after each operation
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {28'd0, nzcv_o}, {28'd0, e});
      check("R12", {31'd0, nzcv_o[2]}, {31'd0, e[2]});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [6];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFFFFFF;
    corner[3] = 32'h80000000; corner[4] = 32'h7FFFFFFF; corner[5] = 32'h12345678;
    #20;
    check("R10", {28'd0, nzcv_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    check("R10", {28'd0, nzcv_o}, 32'd0);

    drive(4'b0100, 32'hFFFFFFFF, 32'h1, 1, 0, 0, 1, "R11");
    drive(4'b0010, 32'h0, 32'h1, 1, 0, 0, 1, "R11");
    drive(4'b0110, 32'h5, 32'h3, 1, 0, 0, 1, "R3");
    drive(4'b0110, 32'h5, 32'h3, 1, 0, 1, 1, "R3");
    drive(4'b0111, 32'h5, 32'h3, 1, 0, 0, 1, "R3");
    drive(4'b0100, 32'h7FFFFFFF, 32'h1, 1, 0, 0, 1, "R2");
    drive(4'b1100, 32'h0, 32'h0, 1, 0, 0, 1, "R1");
    drive(4'b1010, 32'h9, 32'h9, 1, 0, 0, 1, "R4");
    drive(4'b0100, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 0, 1, "R2");
    drive(4'b0100, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 1, "R2");
    drive(4'b0100, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, 0, 0, "R5");

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int c = 0; c < 2; c++)
            drive(4'(op), corner[i], corner[j], 1, 0, c[0], 1, "");

    for (int k = 0; k < 3000; k++)
      drive(4'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom % 4 == 0),
            1'($urandom), 1'($urandom % 8 != 0), "");

    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule